// File: doc/BRIEF.md
# Transposed Three-Tap FIR Filter

This block filters one stream of signed samples with a fixed three-tap finite impulse response. Each output is y(n) = a·x(n) + b·x(n-1) + c·x(n-2). The three coefficients are elaboration-time parameters. Only samples that arrive with their valid strobe count as x(n). Cycles without a strobe leave the filter history untouched.

The structure is the transposed form. Each accepted sample goes to all three constant multipliers in the same cycle. The two history registers sit inside the adder chain, which runs from the c product toward the output, so the longest combinational path is one multiply and one add. A parameter can add a register stage across every multiplier output. That stage is a feed-forward cutset, so it cuts the path to a single multiply at the cost of one extra cycle of latency. The arithmetic is carried at full precision, in a width of sample width plus coefficient width plus two bits. The output is registered together with its valid strobe.

Top module: `fir3_transposed`

## Requirements
- R1: For each accepted sample x(n), the filter emits out_sample = a·x(n) + b·x(n-1) + c·x(n-2) as a two's-complement value. x(n-1) and x(n-2) are the two previously accepted samples, and samples accepted before reset count as zero.
- R2: With PIPE_CUT = 0, out_valid is high in exactly the cycle after each cycle in which in_valid was high.
- R3: With PIPE_CUT = 1, out_valid is high exactly two cycles after each cycle in which in_valid was high. The value sequence is the same as with PIPE_CUT = 0.
- R4: A cycle with in_valid low does not advance the filter history. The value on in_sample in that cycle has no effect on any later output.
- R5: While out_valid is low, out_sample holds the last value the filter emitted.
- R6: A synchronous active-high rst drives out_valid and out_sample to zero on the next clock edge. It clears the history, so the first outputs after reset treat earlier samples as zero.
- R7: At the extreme sample values (-2^(DATA_W-1) and 2^(DATA_W-1)-1) and the most negative coefficient, the output equals the exact mathematical sum with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | High when in_sample carries a new sample |
| in_sample | input | DATA_W | Signed two's-complement input sample |
| out_valid | output | 1 | High when out_sample carries a new filter result |
| out_sample | output | DATA_W+COEF_W+2 | Signed full-precision filter result |

## Verification
The bench builds two copies side by side with DATA_W = 12 and COEF_W = 10. Both use the coefficients 301, -187 and -512. One copy has PIPE_CUT = 1 and the other PIPE_CUT = 0, so both latency variants are checked against one shared reference on the same stimulus. The coefficient -512 is the most negative value a 10-bit coefficient can take. Paired with input samples of -2048 and 2047, it pushes the full-precision sums close to their width limit, which is where a narrower accumulator would wrap. Gaps in in_valid that carry garbage data, and a reset in the middle of a stream, show whether the history moves only on accepted samples and whether reset truly clears it.

// File: rtl/fir3_pkg.sv
package fir3_pkg;
  // Number of taps of the filter (a, b, c).
  localparam int NTAPS = 3;

  // Full-precision accumulator width: product width plus headroom for the sum.
  function automatic int acc_width(input int data_w, input int coef_w);
    return data_w + coef_w + 2;
  endfunction
endpackage

// File: rtl/fir3_tap_bank.sv
// Broadcast multiplier bank: the current sample meets every coefficient at once.
// Optional cutset register stage across all product edges.
module fir3_tap_bank
  import fir3_pkg::*;
#(
  parameter int                         DATA_W   = 12,
  parameter int                         COEF_W   = 10,
  parameter int                         ACC_W    = 24,
  parameter logic [NTAPS*COEF_W-1:0]    COEFS    = '0,
  parameter bit                         PIPE_CUT = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  input  logic [DATA_W-1:0]             in_sample,
  output logic                          prod_valid,
  output logic [NTAPS-1:0][ACC_W-1:0]   prod
);
  logic signed [ACC_W-1:0]       x_ext;
  logic [NTAPS-1:0][ACC_W-1:0]   prod_c;

  assign x_ext = ACC_W'($signed(in_sample));

  for (genvar k = 0; k < NTAPS; k++) begin : g_mul
    localparam logic signed [COEF_W-1:0] CK = COEFS[k*COEF_W +: COEF_W];
    logic signed [ACC_W-1:0] coef_ext;
    assign coef_ext  = ACC_W'(CK);
    assign prod_c[k] = x_ext * coef_ext;
  end

  if (PIPE_CUT) begin : g_cut
    logic                          vld_q;
    logic [NTAPS-1:0][ACC_W-1:0]   prod_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q  <= 1'b0;
        prod_q <= '0;
      end else begin
        vld_q <= in_valid;
        if (in_valid) prod_q <= prod_c;
      end
    end

    assign prod_valid = vld_q;
    assign prod       = prod_q;

    // R4: a cycle without a sample leaves the cutset registers untouched
    assert_cut_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (!in_valid && !rst) |=> $stable(prod_q))
      else $error("cutset stage changed without a sample");
  end else begin : g_direct
    assign prod_valid = in_valid;
    assign prod       = prod_c;
  end
endmodule

// File: rtl/fir3_sum_chain.sv
// Transposed adder chain: delays live between the adders, c tap feeds the far end.
module fir3_sum_chain
  import fir3_pkg::*;
#(
  parameter int ACC_W = 24
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          adv,
  input  logic [NTAPS-1:0][ACC_W-1:0]   prod,
  output logic                          sum_valid,
  output logic [ACC_W-1:0]              sum
);
  logic [ACC_W-1:0] dly [NTAPS];

  // dly[0] is unused; dly[k] holds the partial sum waiting for tap k-1.
  assign dly[0] = '0;

  for (genvar k = 1; k < NTAPS; k++) begin : g_stage
    logic [ACC_W-1:0] nxt;
    if (k == NTAPS - 1) begin : g_far
      assign nxt = prod[k];
    end else begin : g_mid
      assign nxt = prod[k] + dly[k+1];
    end

    always_ff @(posedge clk) begin
      if (rst)      dly[k] <= '0;
      else if (adv) dly[k] <= nxt;
    end

    // R4: history moves only when a sample is accepted
    assert_chain_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (!adv && !rst) |=> $stable(dly[k]))
      else $error("chain register moved without a sample");
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_valid <= 1'b0;
      sum       <= '0;
    end else begin
      sum_valid <= adv;
      if (adv) sum <= prod[0] + dly[1];
    end
  end
endmodule

// File: rtl/fir3_transposed.sv
module fir3_transposed
  import fir3_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int COEF_W   = 10,
  parameter int COEF_A   = 301,
  parameter int COEF_B   = -187,
  parameter int COEF_C   = -512,
  parameter bit PIPE_CUT = 1'b1
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  in_valid,
  input  logic [DATA_W-1:0]                     in_sample,
  output logic                                  out_valid,
  output logic [acc_width(DATA_W, COEF_W)-1:0]  out_sample
);
  localparam int ACC_W = acc_width(DATA_W, COEF_W);
  localparam logic [NTAPS*COEF_W-1:0] COEFS =
    {COEF_W'(COEF_C), COEF_W'(COEF_B), COEF_W'(COEF_A)};

  logic                          prod_valid;
  logic [NTAPS-1:0][ACC_W-1:0]   prod;

  fir3_tap_bank #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W),
    .COEFS(COEFS), .PIPE_CUT(PIPE_CUT)
  ) u_taps (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_sample(in_sample),
    .prod_valid(prod_valid), .prod(prod)
  );

  fir3_sum_chain #(.ACC_W(ACC_W)) u_chain (
    .clk(clk), .rst(rst),
    .adv(prod_valid), .prod(prod),
    .sum_valid(out_valid), .sum(out_sample)
  );

  if (PIPE_CUT) begin : g_lat2
    assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
      out_valid == ($past(in_valid, 2) && !$past(rst, 1) && !$past(rst, 2)))
      else $error("output strobe not two cycles after input strobe");
  end else begin : g_lat1
    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
      out_valid == ($past(in_valid) && !$past(rst)))
      else $error("output strobe not one cycle after input strobe");
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(rst)) |-> $stable(out_sample))
    else $error("output changed without a strobe");

  assert_reset_R6: assert property (@(posedge clk)
    rst |=> (!out_valid && out_sample == '0))
    else $error("reset did not clear the output");
endmodule

// File: tb/fir3_transposed_test.sv
module fir3_transposed_test;
  localparam int DATA_W = 12;
  localparam int COEF_W = 10;
  localparam int ACC_W  = DATA_W + COEF_W + 2;
  localparam longint CA = 301;
  localparam longint CB = -187;
  localparam longint CC = -512;
  localparam int NVEC = 24;

  // Each entry: {valid, sample}
  localparam logic [DATA_W:0] VEC [NVEC] = '{
    {1'b1, 12'h001}, {1'b1, 12'h000}, {1'b1, 12'h000}, {1'b1, 12'h000}, // R1 impulse
    {1'b0, 12'h7FF}, {1'b0, 12'h800}, {1'b1, 12'h003}, {1'b0, 12'h555}, // R4 gaps
    {1'b1, 12'hFFE}, {1'b1, 12'h010}, {1'b0, 12'hABC}, {1'b1, 12'h000},
    {1'b1, 12'h800}, {1'b1, 12'h800}, {1'b1, 12'h800}, {1'b1, 12'h7FF}, // R7 extremes
    {1'b1, 12'h7FF}, {1'b1, 12'h800}, {1'b1, 12'h7FF},
    {1'b1, 12'h000}, {1'b1, 12'h000}, {1'b0, 12'h000}, {1'b0, 12'h000}, {1'b0, 12'h123}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [DATA_W-1:0] in_sample = '0;
  logic pv, fv;
  logic [ACC_W-1:0] py, fy;

  int n_tests = 0;
  int n_fail  = 0;

  // reference state
  longint h1 = 0, h2 = 0;
  logic   ef_v = 1'b0, ep0_v = 1'b0, ep1_v = 1'b0;
  longint ef_d = 0, ep0_d = 0, ep1_d = 0;
  longint last_f = 0, last_p = 0;

  always #4 clk = ~clk;

  fir3_transposed #(.DATA_W(DATA_W), .COEF_W(COEF_W), .COEF_A(301), .COEF_B(-187),
    .COEF_C(-512), .PIPE_CUT(1'b1)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(pv), .out_sample(py));

  fir3_transposed #(.DATA_W(DATA_W), .COEF_W(COEF_W), .COEF_A(301), .COEF_B(-187),
    .COEF_C(-512), .PIPE_CUT(1'b0)) uut_flat (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(fv), .out_sample(fy));

  task automatic check_val(input string req, input string what, input longint got, input longint exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic longint sval(input logic [ACC_W-1:0] v);
    return longint'($signed(v));
  endfunction

  // Check outputs for the previous cycle, then drive one new cycle.
  task automatic step(input logic v, input logic [DATA_W-1:0] x, input string tag);
    longint e;
    @(negedge clk);
    check_val("R2", "flat strobe", longint'(fv), longint'(ef_v));
    if (ef_v) begin
      check_val(tag, "flat value", sval(fy), ef_d);
      last_f = ef_d;
    end else check_val("R5", "flat hold", sval(fy), last_f);
    check_val("R3", "piped strobe", longint'(pv), longint'(ep1_v));
    if (ep1_v) begin
      check_val(tag, "piped value", sval(py), ep1_d);
      last_p = ep1_d;
    end else check_val("R5", "piped hold", sval(py), last_p);

    in_valid  = v;
    in_sample = x;
    e = 0;
    if (v) begin
      e  = CA * longint'($signed(x)) + CB * h1 + CC * h2;
      h2 = h1;
      h1 = longint'($signed(x));
    end
    ep1_v = ep0_v; ep1_d = ep0_d;
    ep0_v = v;     ep0_d = e;
    ef_v  = v;     ef_d  = e;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; in_sample = 12'h5A5;
    @(negedge clk);
    @(negedge clk);
    check_val("R6", "flat strobe in reset", longint'(fv), 0);
    check_val("R6", "flat value in reset", sval(fy), 0);
    check_val("R6", "piped strobe in reset", longint'(pv), 0);
    check_val("R6", "piped value in reset", sval(py), 0);
    rst = 1'b0;
    h1 = 0; h2 = 0;
    ef_v = 0; ep0_v = 0; ep1_v = 0;
    ef_d = 0; ep0_d = 0; ep1_d = 0;
    last_f = 0; last_p = 0;
  endtask

  initial begin
    #80000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    for (int i = 0; i < NVEC; i++) begin
      string tag;
      if (i >= 4 && i < 12)       tag = "R4";
      else if (i >= 12 && i < 19) tag = "R7";
      else                        tag = "R1";
      step(VEC[i][DATA_W], VEC[i][DATA_W-1:0], tag);
    end
    // Load nonzero history, then reset mid-stream: impulse must see zero history (R6)
    step(1'b1, 12'h7FF, "R7");
    step(1'b1, 12'h800, "R7");
    do_reset();
    step(1'b1, 12'h001, "R6");
    step(1'b1, 12'h000, "R6");
    step(1'b1, 12'h000, "R6");
    // Long gap with changing garbage data, then one sample (R4, R5)
    for (int i = 0; i < 5; i++) step(1'b0, 12'(i * 333), "R4");
    step(1'b1, 12'hF00, "R4");
    // Alternating strobes (R2, R3)
    for (int i = 0; i < 6; i++) step(1'(i % 2), 12'(i * 91 - 200), "R1");
    for (int i = 0; i < 3; i++) step(1'b0, 12'h000, "R1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule